// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits on the receive path after the CRC checker and before the buffer writer. It takes one received frame at a time as a byte stream, with start, end and CRC-status flags, and passes the bytes to a downstream writer. One cycle after the last input byte it gives a verdict saying whether the frame should be kept. Two checks feed the verdict. The first compares the frame's length/type field with the data length actually received. The second looks at the CRC status supplied with the last byte. When the length/type value is at least 0x0600 it is treated as a type ID and never counts as a length error.

Three static settings shape the output stream. One strips the four trailing FCS bytes. Another inserts zero to three zero-valued pad bytes ahead of the first frame byte, so the frame lands at an offset inside its first buffer. A third accepts frames even when their CRC is bad, and in that case no FCS-error pulse is raised. All settings must stay constant from the first byte of a frame until its verdict.

Both byte streams use valid/ready. A byte moves only in a cycle where valid and ready are both high. A source must hold valid and the data stable until the byte is taken. The block lowers `in_ready` whenever it has an output byte that the sink is not taking. It also lowers `in_ready` while it emits pad bytes. While stripping, it takes the first four bytes of a frame without producing output, because it needs them as a delay line.

Top module: `rxf_filter`

## Requirements
- R1: Frame bytes leave in arrival order and unchanged. `out_sof` marks the first output byte of a frame and `out_eof` marks the last.
- R2: An offset code k (`cfg_offset` = 0, 1, 2 or 3) emits k bytes of value 0x00 ahead of the first frame byte. The first pad byte carries `out_sof`.
- R3: With `cfg_strip_fcs` high, the final four bytes of the frame are not emitted, and `out_eof` moves to the fifth-from-last byte.
- R4: With `cfg_len_chk` high, a frame of N bytes whose length field L (byte 12 high, byte 13 low, 0-based) is below 0x0600 gets a length error when N−18 < L. With `cfg_len_chk` low, no length error is flagged.
- R5: A length/type value of 0x0600 or above never produces a length error.
- R6: A frame shorter than 14 bytes never produces a length error.
- R7: With `cfg_ignore_fcs` low and `in_crc_bad` high on the last byte, the verdict flags an FCS error and discards the frame, and `fcs_err_pulse` is high for that verdict cycle.
- R8: With `cfg_ignore_fcs` high, a bad CRC flags no FCS error and raises no `fcs_err_pulse`.
- R9: `vd_valid` pulses in the cycle after the last byte is accepted. `vd_keep` is high only when neither error flag is set. `vd_bytes` counts the frame bytes written, excluding pad bytes and stripped bytes.
- R10: While an output byte waits on `out_ready`, no input byte is accepted and nothing is lost or reordered.
- R11: After reset `out_valid`, `vd_valid` and `fcs_err_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | First byte of the frame |
| in_eof | input | 1 | Last byte of the frame |
| in_crc_bad | input | 1 | CRC failed; sampled with the last byte |
| cfg_len_chk | input | 1 | Enable length-field check |
| cfg_strip_fcs | input | 1 | Drop the four FCS bytes |
| cfg_ignore_fcs | input | 1 | Accept frames with a bad CRC |
| cfg_offset | input | 2 | Number of leading pad bytes |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of the frame |
| out_eof | output | 1 | Last output byte of the frame |
| vd_valid | output | 1 | Verdict strobe |
| vd_keep | output | 1 | Keep the frame |
| vd_len_err | output | 1 | Length error |
| vd_fcs_err | output | 1 | FCS error |
| vd_bytes | output | 16 | Bytes written for the frame, pad excluded |
| fcs_err_pulse | output | 1 | One-cycle FCS-error count strobe |

## Verification
A wrong header-byte counter shows up at the verdict of the same frame. The length field would be read from the wrong position, so `vd_len_err` and `vd_bytes` would disagree with the values worked out from the frame the next cycle after its last byte. A wrong fill count in the FCS delay line shows at the output stream within the frame. Bytes would come out shifted, duplicated or with a misplaced `out_eof`, and the scoreboard compares every byte as it is taken. A pad counter that fails to clear shows on the next frame as a missing or extra zero before `out_sof` data. Random back-pressure on `out_ready` exposes any byte that is lost or repeated during a stall.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int FCS_BYTES = 4;
  localparam int HDR_BYTES = 14;
  localparam int LF_HI_IDX = 12;
  localparam logic [15:0] TYPE_MIN = 16'h0600;

  typedef struct packed {
    logic keep;
    logic len_err;
    logic fcs_err;
  } rxf_flags_t;
endpackage

// File: rtl/rxf_shaper.sv
module rxf_shaper #(
  parameter int HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       cfg_strip,
  input  logic [1:0] cfg_offset,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  localparam int HW = $clog2(HOLD + 1);

  logic [7:0]    hold_q [HOLD];
  logic [HW-1:0] hold_n_q;
  logic [1:0]    pad_q;
  logic          open_q;
  logic          pad_phase, absorb, in_fire, out_fire;

  assign pad_phase = in_valid && in_sof && (pad_q != cfg_offset);
  assign absorb    = cfg_strip && (hold_n_q != HW'(HOLD));
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'd0;
    out_eof   = 1'b0;
    in_ready  = out_ready;
    if (pad_phase) begin
      out_valid = 1'b1;
      in_ready  = 1'b0;
    end else if (absorb) begin
      in_ready  = 1'b1;
    end else begin
      out_valid = in_valid;
      out_data  = cfg_strip ? hold_q[0] : in_data;
      out_eof   = in_eof;
    end
  end

  assign out_sof = out_valid && !open_q;

  // delay line: oldest byte at index 0, newest enters at the top
  for (genvar g = 0; g < HOLD; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)
        hold_q[g] <= 8'd0;
      else if (in_fire)
        hold_q[g] <= (g == HOLD - 1) ? in_data : hold_q[(g + 1) % HOLD];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_n_q <= '0;
      pad_q    <= 2'd0;
      open_q   <= 1'b0;
    end else begin
      if (in_fire && in_eof)
        hold_n_q <= '0;
      else if (in_fire && absorb)
        hold_n_q <= hold_n_q + HW'(1);

      if (in_fire && in_eof)
        pad_q <= 2'd0;
      else if (out_fire && pad_phase)
        pad_q <= pad_q + 2'd1;

      if (in_fire && in_eof)
        open_q <= 1'b0;
      else if (out_fire)
        open_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxf_judge.sv
module rxf_judge
  import rxf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fire,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_bad,
  input  logic             cfg_len_chk,
  input  logic             cfg_strip,
  input  logic             cfg_ignore_fcs,
  output logic             vd_valid,
  output rxf_flags_t       vd_flags,
  output logic [CNT_W-1:0] vd_bytes
);
  localparam int CMP_W = ((CNT_W > 16) ? CNT_W : 16) + 1;

  logic [CNT_W-1:0] cnt_q, idx, total, bytes;
  logic [7:0]       lf_hi_q, lf_lo_q;
  logic [15:0]      lf_now;
  logic             has_field, is_type, too_short, len_err, fcs_err;

  assign idx       = in_sof ? '0 : cnt_q;
  assign total     = idx + CNT_W'(1);
  assign lf_now    = {lf_hi_q, (idx == CNT_W'(LF_HI_IDX + 1)) ? in_data : lf_lo_q};
  assign has_field = total >= CNT_W'(HDR_BYTES);
  assign is_type   = lf_now >= TYPE_MIN;
  assign too_short = CMP_W'(total) < (CMP_W'(lf_now) + CMP_W'(HDR_BYTES + FCS_BYTES));
  assign len_err   = cfg_len_chk && has_field && !is_type && too_short;
  assign fcs_err   = in_crc_bad && !cfg_ignore_fcs;
  assign bytes     = !cfg_strip ? total :
                     (total > CNT_W'(FCS_BYTES)) ? total - CNT_W'(FCS_BYTES) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      lf_hi_q  <= 8'd0;
      lf_lo_q  <= 8'd0;
      vd_valid <= 1'b0;
      vd_flags <= '0;
      vd_bytes <= '0;
    end else begin
      vd_valid <= in_fire && in_eof;
      if (in_fire) begin
        cnt_q <= total;
        if (idx == CNT_W'(LF_HI_IDX))     lf_hi_q <= in_data;
        if (idx == CNT_W'(LF_HI_IDX + 1)) lf_lo_q <= in_data;
        if (in_eof) begin
          vd_flags.keep    <= !(len_err || fcs_err);
          vd_flags.len_err <= len_err;
          vd_flags.fcs_err <= fcs_err;
          vd_bytes         <= bytes;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter
  import rxf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_bad,
  input  logic             cfg_len_chk,
  input  logic             cfg_strip_fcs,
  input  logic             cfg_ignore_fcs,
  input  logic [1:0]       cfg_offset,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             vd_valid,
  output logic             vd_keep,
  output logic             vd_len_err,
  output logic             vd_fcs_err,
  output logic [CNT_W-1:0] vd_bytes,
  output logic             fcs_err_pulse
);
  rxf_flags_t flags;
  logic       in_fire;

  assign in_fire = in_valid && in_ready;

  rxf_shaper #(.HOLD(FCS_BYTES)) shaper_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .cfg_strip(cfg_strip_fcs), .cfg_offset(cfg_offset),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  rxf_judge #(.CNT_W(CNT_W)) judge_i (
    .clk(clk), .rst_n(rst_n),
    .in_fire(in_fire), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_bad(in_crc_bad), .cfg_len_chk(cfg_len_chk),
    .cfg_strip(cfg_strip_fcs), .cfg_ignore_fcs(cfg_ignore_fcs),
    .vd_valid(vd_valid), .vd_flags(flags), .vd_bytes(vd_bytes)
  );

  assign vd_keep       = flags.keep;
  assign vd_len_err    = flags.len_err;
  assign vd_fcs_err    = flags.fcs_err;
  assign fcs_err_pulse = vd_valid && flags.fcs_err;
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_eof,
  input logic       in_crc_bad,
  input logic       cfg_ignore_fcs,
  input logic [1:0] cfg_offset,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       vd_valid,
  input logic       vd_fcs_err,
  input logic       fcs_err_pulse
);
  a_r9_verdict_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eof) |=> vd_valid);

  a_r9_verdict_needs_eof: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |-> $past(in_valid && in_ready && in_eof));

  a_r8_ignore_no_fcs: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && $past(cfg_ignore_fcs)) |-> (!vd_fcs_err && !fcs_err_pulse));

  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_err_pulse |-> $past(in_valid && in_ready && in_eof && in_crc_bad && !cfg_ignore_fcs));

  a_r10_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !(in_valid && in_ready));

  a_r2_pad_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof && cfg_offset != 2'd0) |-> (out_data == 8'd0));
endmodule

bind rxf_filter rxf_filter_chk chk_i (.*);

// File: tb/rxf_filter_tb.sv
module rxf_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_crc_bad = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        cfg_len_chk = 1'b0, cfg_strip_fcs = 1'b0, cfg_ignore_fcs = 1'b0;
  logic [1:0]  cfg_offset = 2'd0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_sof, out_eof;
  logic [7:0]  out_data;
  logic        vd_valid, vd_keep, vd_len_err, vd_fcs_err, fcs_err_pulse;
  logic [15:0] vd_bytes;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  logic [9:0]  exp_q[$];   // {data, sof, eof}
  logic [18:0] vd_q[$];    // {keep, len_err, fcs_err, bytes}
  logic        bp_en = 1'b0;
  logic [7:0]  lfsr = 8'h5B;

  always #4 clk = ~clk;

  rxf_filter dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !out_ready && in_valid && in_ready)
        check(0, "R10", "input taken during stall", 1, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check(0, {cur_req, " R1"}, "unexpected byte", {22'd0, out_data, out_sof, out_eof}, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check({out_data, out_sof, out_eof} == e, {cur_req, " R1"}, "out byte",
                {22'd0, out_data, out_sof, out_eof}, {22'd0, e});
        end
      end
      if (vd_valid) begin
        if (vd_q.size() == 0)
          check(0, {cur_req, " R9"}, "unexpected verdict", 1, 0);
        else begin
          logic [18:0] v;
          v = vd_q.pop_front();
          check({vd_keep, vd_len_err, vd_fcs_err, vd_bytes} == v, {cur_req, " R9"}, "verdict",
                {13'd0, vd_keep, vd_len_err, vd_fcs_err, vd_bytes}, {13'd0, v});
          check(fcs_err_pulse == v[16], {cur_req, " R7 R8"}, "fcs pulse", fcs_err_pulse, v[16]);
        end
      end else if (fcs_err_pulse)
        check(0, "R7", "pulse without verdict", 1, 0);
    end
  end

  function automatic logic [7:0] fbyte(int i, logic [15:0] lf);
    if (i == 12) return lf[15:8];
    if (i == 13) return lf[7:0];
    return 8'(i * 7 + 8'h31);
  endfunction

  task automatic send(input string req, input int n, input logic [15:0] lf, input bit bad,
                      input bit chk, input bit strip, input bit ign, input logic [1:0] off,
                      input bit bp);
    int nout;
    int total_out;
    bit lerr, ferr;
    cur_req = req;
    cfg_len_chk = chk; cfg_strip_fcs = strip; cfg_ignore_fcs = ign; cfg_offset = off;
    bp_en = bp;
    nout = strip ? ((n > 4) ? n - 4 : 0) : n;
    total_out = int'(off) + nout;
    for (int p = 0; p < int'(off); p++)
      exp_q.push_back({8'd0, p == 0, (nout == 0) && (p == total_out - 1)});
    for (int i = 0; i < nout; i++)
      exp_q.push_back({fbyte(i, lf), (int'(off) == 0) && (i == 0), i == nout - 1});
    lerr = chk && (n >= 14) && (lf < 16'h0600) && (n < int'(lf) + 18);
    ferr = bad && !ign;
    vd_q.push_back({!(lerr || ferr), lerr, ferr, 16'(nout)});
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = fbyte(i, lf);
      in_sof = (i == 0); in_eof = (i == n - 1); in_crc_bad = bad && (i == n - 1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_crc_bad = 1'b0;
    @(negedge clk);
    check(vd_valid == 1'b1, {req, " R9"}, "verdict cycle after last byte", vd_valid, 1);
    for (int w = 0; w < 200 && (exp_q.size() != 0 || vd_q.size() != 0); w++) @(negedge clk);
    check(exp_q.size() == 0 && vd_q.size() == 0, {req, " R1"}, "leftover items",
          exp_q.size() + vd_q.size(), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(out_valid == 0 && vd_valid == 0 && fcs_err_pulse == 0, "R11", "reset outputs",
          {out_valid, vd_valid, fcs_err_pulse}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    //   req                n   lf        bad chk strip ign off bp
    send("R1 R5",          64, 16'h0800, 0,  1,  0,   0,  0,  0);
    send("R2 R3 R10",      64, 16'd46,   0,  1,  1,   0,  2,  1);
    send("R4 boundary",    64, 16'd47,   0,  1,  0,   0,  1,  0);
    send("R4 check off",   64, 16'd47,   0,  0,  0,   0,  0,  1);
    send("R5 at 0x0600",   20, 16'h0600, 0,  1,  0,   0,  0,  0);
    send("R5 below type",  64, 16'h05FF, 0,  1,  0,   0,  3,  0);
    send("R6 10 bytes",    10, 16'd0,    0,  1,  0,   0,  0,  0);
    send("R6 13 bytes",    13, 16'd0,    0,  1,  0,   0,  1,  1);
    send("R6 R4 14 bytes", 14, 16'd0,    0,  1,  0,   0,  0,  0);
    send("R7",             30, 16'h0800, 1,  1,  0,   0,  0,  0);
    send("R8",             30, 16'h0800, 1,  1,  0,   1,  0,  1);
    send("R2 R3 R7 R10",   40, 16'd22,   1,  1,  1,   0,  3,  1);
    send("R3 R1",          18, 16'd0,    0,  1,  1,   0,  1,  0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule